// File: doc/BRIEF.md
# Two-Read One-Write Integer Register File

This block is the general-purpose integer register storage of a small 32-bit datapath. It holds 32 registers of 32 bits. Two independent read ports each take a 5-bit register number and return that register's contents through multiplexers, with no clock involved. A change of read number shows on the read data after combinational delay only.

A single write port takes a 5-bit destination number, a 32-bit value and a one-bit enable. Writes are committed on the falling clock edge, so the rising edge stays free for control-state transitions elsewhere in the datapath. A value written at the falling edge can therefore be read back in the second half of the same cycle, before the next rising edge. An active-high synchronous reset, also sampled on the falling edge, clears every register.

Top module: `dual_read_regfile`

## Requirements
- R1: The file holds 32 independent registers of 32 bits, each addressed by a 5-bit unsigned number (0 to 31). Every register keeps its own value and can be read back unaltered.
- R2: Read port A drives `rd_a_val` with the register selected by `rd_a_sel`. A change of `rd_a_sel` is reflected with no clock edge in between.
- R3: Read port B drives `rd_b_val` with the register selected by `rd_b_sel`, independently of port A and with the same combinational behaviour.
- R4: When both read ports select the same register, both return that register's value.
- R5: With `wr_en` = 1 at a falling clock edge, `wr_val` is stored into the register numbered `wr_sel`. No other register changes.
- R6: With `wr_en` = 0 at a falling clock edge, no register changes, whatever `wr_sel` and `wr_val` hold.
- R7: Writes commit only at the falling edge. A write presented after a rising edge is not visible before the following falling edge.
- R8: After a falling-edge write, a read port selecting the written register shows the new value before the next rising edge.
- R9: With `rst` = 1 at a falling edge, all 32 registers become zero. Reset takes priority over a write enabled at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst | input | 1 | Active-high synchronous clear, sampled on the falling edge |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_val | output | 32 | Contents of the register selected for port A |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_val | output | 32 | Contents of the register selected for port B |
| wr_en | input | 1 | Write enable; 1 stores at the falling edge |
| wr_sel | input | 5 | Destination register number |
| wr_val | input | 32 | Value to store |

## Verification
A falling-edge write and a combinational read of the same register can fall in one cycle. This is the case where a stale value or a read taken from the wrong clock edge would show. The bench provokes it by presenting a write and pointing a read port at the destination. It samples once just before the falling edge, where the old value is expected, and once just after it, before the next rising edge, where the new value is expected. The expected values come from a shadow array that the bench updates at each falling edge. Reset and an enabled write are also presented together at one edge, and the bench expects the cleared value.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

  localparam int DEF_NUM_REGS = 32;
  localparam int DEF_DATA_W   = 32;

  // Number of bits needed to name one of n entries (at least 1).
  function automatic int idx_width(input int n);
    int w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
  parameter int NREGS = 32,
  parameter int IW    = 5
) (
  input  logic             en,
  input  logic [IW-1:0]    sel,
  output logic [NREGS-1:0] strobe
);

  // One load strobe per register; none when the enable is low.
  function automatic logic [NREGS-1:0] decode(input logic e, input logic [IW-1:0] s);
    logic [NREGS-1:0] v;
    v = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (e && (s == IW'(i))) v[i] = 1'b1;
    end
    return v;
  endfunction

  assign strobe = decode(en, sel);

endmodule

// File: rtl/rf_cell.sv
`timescale 1ns/1ps
module rf_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Falling-edge storage; clear wins over load.
  always_ff @(negedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/rf_rd_mux.sv
`timescale 1ns/1ps
module rf_rd_mux #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  parameter int IW    = 5
) (
  input  logic [NREGS-1:0][W-1:0] bank,
  input  logic [IW-1:0]           sel,
  output logic [W-1:0]            val
);

  // Purely combinational selection; an out-of-range number reads zero.
  always_comb begin
    val = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (sel == IW'(i)) val = bank[i];
    end
  end

endmodule

// File: rtl/dual_read_regfile.sv
`timescale 1ns/1ps
module dual_read_regfile #(
  parameter int NUM_REGS = rf_pkg::DEF_NUM_REGS,
  parameter int DATA_W   = rf_pkg::DEF_DATA_W,
  localparam int IDX_W   = rf_pkg::idx_width(NUM_REGS),
  localparam int NRD     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_sel,
  output logic [DATA_W-1:0] rd_a_val,
  input  logic [IDX_W-1:0]  rd_b_sel,
  output logic [DATA_W-1:0] rd_b_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_val
);

  // Named internal events for the checker.
  logic [NUM_REGS-1:0]             wr_strobe;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;

  logic [NRD-1:0][IDX_W-1:0]  rd_sel;
  logic [NRD-1:0][DATA_W-1:0] rd_val;

  assign rd_sel[0] = rd_a_sel;
  assign rd_sel[1] = rd_b_sel;
  assign rd_a_val  = rd_val[0];
  assign rd_b_val  = rd_val[1];

  rf_wr_decode #(.NREGS(NUM_REGS), .IW(IDX_W)) u_dec (
    .en    (wr_en),
    .sel   (wr_sel),
    .strobe(wr_strobe)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    rf_cell #(.W(DATA_W)) u_cell (
      .clk (clk),
      .rst (rst),
      .load(wr_strobe[g]),
      .d   (wr_val),
      .q   (bank_q[g])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_rd_mux #(.NREGS(NUM_REGS), .W(DATA_W), .IW(IDX_W)) u_mux (
      .bank(bank_q),
      .sel (rd_sel[p]),
      .val (rd_val[p])
    );
  end

endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  parameter int IW    = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [IW-1:0]         wr_sel,
  input logic [W-1:0]          wr_val,
  input logic [IW-1:0]         rd_a_sel,
  input logic [W-1:0]          rd_a_val,
  input logic [IW-1:0]         rd_b_sel,
  input logic [W-1:0]          rd_b_val,
  input logic [NREGS-1:0]      wr_strobe,
  input logic [NREGS-1:0][W-1:0] bank_q
);

  logic rst_seen = 1'b0;
  always_ff @(negedge clk) rst_seen <= rst;

  // R5
  write_lands_chk: assert property (@(negedge clk) disable iff (rst)
    wr_en |=> (bank_q[$past(wr_sel)] == $past(wr_val)));

  // R5
  single_target_chk: assert property (@(negedge clk) disable iff (rst)
    $onehot0(wr_strobe));

  // R6
  idle_hold_chk: assert property (@(negedge clk) disable iff (rst)
    !wr_en |=> $stable(bank_q));

  // R2
  port_a_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_val == bank_q[rd_a_sel]);

  // R3
  port_b_chk: assert property (@(posedge clk) disable iff (rst)
    rd_b_val == bank_q[rd_b_sel]);

  // R4
  same_index_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_sel == rd_b_sel) |-> (rd_a_val == rd_b_val));

  // R9
  always @(negedge clk) begin
    if (rst_seen) begin
      reset_clear_chk: assert (bank_q == '0)
        else $error("register file not cleared after reset");
    end
  end

endmodule

bind dual_read_regfile rf_checker #(.NREGS(NUM_REGS), .W(DATA_W), .IW(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_val   (wr_val),
  .rd_a_sel (rd_a_sel),
  .rd_a_val (rd_a_val),
  .rd_b_sel (rd_b_sel),
  .rd_b_val (rd_b_val),
  .wr_strobe(wr_strobe),
  .bank_q   (bank_q)
);

// File: tb/sim_dual_read_regfile.sv
`timescale 1ns/1ps
module sim_dual_read_regfile;
  localparam int N  = 32;
  localparam int W  = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1;
  logic [IW-1:0] rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [W-1:0]  rd_a_val, rd_b_val, wr_val = '0;
  logic          wr_en = 1'b0;

  logic [W-1:0] shadow [N];
  int checks = 0;
  int errors = 0;

  dual_read_regfile u0 (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_val(rd_a_val),
    .rd_b_sel(rd_b_sel), .rd_b_val(rd_b_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val)
  );

  function automatic logic [W-1:0] pat(input int i, input int salt);
    return (W'(i) * 32'h0101_0101) ^ (W'(salt) * 32'h9E37_79B9) ^ 32'h5A00_00A5;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive after the rising edge, model the falling edge, sample after it.
  task automatic cyc(input bit r, input bit en, input int ws, input logic [W-1:0] wv,
                     input int ra, input int rb, input string req);
    @(posedge clk); #1;
    rst = r; wr_en = en; wr_sel = IW'(ws); wr_val = wv;
    rd_a_sel = IW'(ra); rd_b_sel = IW'(rb);
    @(negedge clk);
    if (r) begin
      for (int k = 0; k < N; k++) shadow[k] = '0;
    end else if (en) begin
      shadow[ws] = wv;
    end
    #1;
    chk(req, rd_a_val, shadow[ra]);
    chk(req, rd_b_val, shadow[rb]);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) shadow[k] = '0;

    // R9: reset with an enabled write at the same edge; reset wins
    cyc(1, 1, 5, 32'hDEAD_BEEF, 5, 0, "R9");
    cyc(1, 1, 9, 32'h1234_5678, 9, 5, "R9");
    for (int i = 0; i < N; i++) cyc(0, 0, 0, '0, i, N - 1 - i, "R9 cleared");

    // R5 + R8: fill every register, read back right after the falling edge
    for (int i = 0; i < N; i++) cyc(0, 1, i, pat(i, 1), i, (i + 3) % N, "R5+R8");

    // R1: every register retains its own value
    for (int i = 0; i < N; i++) cyc(0, 0, 0, '0, i, (i + 7) % N, "R1");

    // R6: disabled writes aimed at every register change nothing
    for (int i = 0; i < N; i++) cyc(0, 0, i, ~pat(i, 1), i, (i + 1) % N, "R6");

    // R4: both ports on the written register
    for (int i = 0; i < N; i++) cyc(0, 1, i, pat(i, 2), i, i, "R4");

    // R7 then R8: not visible before the falling edge, visible right after
    for (int i = 0; i < 8; i++) begin
      int t;
      t = (i * 5 + 2) % N;
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = IW'(t); wr_val = pat(t, 40 + i);
      rd_a_sel = IW'(t); rd_b_sel = IW'(t);
      #1;
      chk("R7", rd_a_val, shadow[t]);
      chk("R7", rd_b_val, shadow[t]);
      @(negedge clk);
      shadow[t] = pat(t, 40 + i);
      #1;
      chk("R8", rd_a_val, shadow[t]);
      chk("R8", rd_b_val, shadow[t]);
    end

    // R2 + R3: read numbers changed between edges follow with no clock
    @(posedge clk); #1; wr_en = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); #0.5;
      for (int k = 0; k < 4; k++) begin
        int a, b;
        a = (c * 4 + k) % N;
        b = N - 1 - a;
        rd_a_sel = IW'(a); rd_b_sel = IW'(b);
        #0.3;
        chk("R2", rd_a_val, shadow[a]);
        chk("R3", rd_b_val, shadow[b]);
      end
    end

    // R5/R6/R4 mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int ws, ra, rb;
      bit en;
      ws = int'($urandom_range(N - 1));
      ra = int'($urandom_range(N - 1));
      rb = ($urandom_range(3) == 0) ? ra : int'($urandom_range(N - 1));
      if ($urandom_range(1) == 1) ra = ws;
      en = ($urandom_range(2) != 0);
      cyc(0, en, ws, $urandom, ra, rb, en ? "R5 random" : "R6 random");
    end

    // R9: reset in the middle of traffic
    cyc(1, 1, 17, 32'hFFFF_FFFF, 17, 4, "R9 midrun");
    for (int i = 0; i < N; i++) cyc(0, 0, 0, '0, i, i, "R9 midrun cleared");

    finish_run();
  end

endmodule